// File: doc/BRIEF.md
# Partial-Flag Offset Register Loader

This block holds the two offsets that a FIFO's partial-flag logic compares against. One offset sets how close to empty the almost-empty flag fires, and the other sets how close to full the almost-full flag fires. Both offsets are loaded through the write-side ports, on one clock that the load and readback logic share. The block supports two ways of loading them. In word-parallel mode, words are taken from the write data bus while a load strobe is held. In bit-serial mode, a single data pin is shifted in under its own enable. A configuration pin is sampled only while master reset is held, and it fixes both the loading method and the value the offsets start from.

Either offset can be read back onto the read data bus at any time, in either mode. Reads and writes keep separate slot pointers, so a readback does not disturb a load that is part way done. Partial reset returns all pointers to the first slot and leaves the stored offsets and the chosen mode in place. Neither port applies back-pressure. A qualified write or shift is always taken in the cycle it is presented. A qualified read always returns its word in the next cycle, flagged by a one-cycle valid pulse.

Top module: `ofs_loader`

## Requirements
- R1: While `mrst_n` is low, the latched mode takes `cfg_serial`. With `cfg_serial`=0 both offsets become 127 and parallel loading is selected (`ser_mode`=0). With `cfg_serial`=1 both offsets become 1023 and serial loading is selected (`ser_mode`=1). All values are visible one cycle after the reset edge.
- R2: After master reset is released, `ser_mode` does not change until the next master reset, whatever `cfg_serial` does.
- R3: In parallel mode, each cycle with `ld`=1 and `wr_en`=1 stores `wr_data` into one offset, visible next cycle. The first such cycle after a reset writes the almost-empty offset, the next writes the almost-full offset, and the two then keep alternating.
- R4: In serial mode, each cycle with `ser_en`=1 stores `ser_din` into one bit. The bits form one chain of 2·OFS_W positions: almost-empty bit 0 up to its MSB, then almost-full bit 0 up to its MSB. After the last position the chain wraps to almost-empty bit 0.
- R5: In parallel mode `ser_en`/`ser_din` leave both offsets unchanged. In serial mode `wr_en` writes leave both offsets unchanged.
- R6: In either mode, a cycle with `ld`=1 and `rd_en`=1 gives `rd_valid`=1 in the next cycle, with `rd_data` equal to an offset. The first read after a reset returns the almost-empty offset, the next returns the almost-full offset, and they keep alternating. In any other cycle `rd_valid` is 0 in the next cycle.
- R7: The read slot pointer and the write slot pointer advance independently. A parallel write does not move the read slot, and a read does not move the write slot.
- R8: While `prst_n` is low (and `mrst_n` high), the offsets and `ser_mode` keep their values and all writes, shifts and reads are ignored. Afterwards, writes, reads and the serial chain restart at the almost-empty slot and bit 0.
- R9: With `ld`=0, `wr_en` leaves the offsets unchanged and `rd_en` produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by loading and readback |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| cfg_serial | input | 1 | Method/default select, sampled during master reset |
| ld | input | 1 | Load strobe qualifying parallel writes and reads |
| wr_en | input | 1 | Parallel write enable |
| wr_data | input | OFS_W | Parallel write word |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| rd_en | input | 1 | Readback enable |
| rd_data | output | OFS_W | Readback word |
| rd_valid | output | 1 | Readback word valid, one-cycle pulse |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| ser_mode | output | 1 | Latched method: 1 serial, 0 parallel |

## Verification
The assertions assume that the first clock edges see `mrst_n` low. They also assume that `prst_n` and `mrst_n` are treated as synchronous levels and not as glitches between edges. The bench starts every scenario with a master reset and changes all inputs one time unit after a rising edge. It also toggles `cfg_serial` outside reset and presents foreign-mode stimulus on purpose, so that the stability properties are exercised on the paths they guard.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Slot selector shared by the write and read pointers
  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } slot_e;

  function automatic slot_e next_slot(input slot_e s);
    return (s == SLOT_AE) ? SLOT_AF : SLOT_AE;
  endfunction
endpackage

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
  import ofs_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int CNT_W = $clog2(2 * OFS_W)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ser_mode,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             ser_en,
  output logic             par_we,
  output slot_e            par_sel,
  output logic             ser_we,
  output slot_e            ser_sel,
  output logic [CNT_W-1:0] ser_pos
);
  localparam int CHAIN = 2 * OFS_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAIN - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(OFS_W);

  slot_e            wptr_q;
  logic [CNT_W-1:0] bit_q;
  logic             live;

  assign live    = mrst_n && prst_n;
  assign par_we  = live && !ser_mode && ld && wr_en;
  assign ser_we  = live && ser_mode && ser_en;
  assign par_sel = wptr_q;
  assign ser_sel = (bit_q >= HALF) ? SLOT_AF : SLOT_AE;
  assign ser_pos = (bit_q >= HALF) ? (bit_q - HALF) : bit_q;

  always_ff @(posedge clk) begin
    if (!live) begin
      wptr_q <= SLOT_AE;
      bit_q  <= '0;
    end else begin
      if (par_we) wptr_q <= next_slot(wptr_q);
      if (ser_we) bit_q  <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023,
  parameter int CNT_W   = $clog2(2 * OFS_W)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             cfg_serial,
  input  logic             par_we,
  input  slot_e            par_sel,
  input  logic [OFS_W-1:0] par_word,
  input  logic             ser_we,
  input  slot_e            ser_sel,
  input  logic [CNT_W-1:0] ser_pos,
  input  logic             ser_din,
  output logic [OFS_W-1:0] ae,
  output logic [OFS_W-1:0] af,
  output logic             ser_mode
);
  localparam logic [OFS_W-1:0] INIT_PAR = OFS_W'(DEF_PAR);
  localparam logic [OFS_W-1:0] INIT_SER = OFS_W'(DEF_SER);

  always_ff @(posedge clk) begin
    if (!mrst_n) ser_mode <= cfg_serial;
  end

  for (genvar r = 0; r < 2; r++) begin : g_slot
    localparam slot_e ME = slot_e'(1'(r));
    logic [OFS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!mrst_n) begin
        q <= cfg_serial ? INIT_SER : INIT_PAR;
      end else if (par_we && par_sel == ME) begin
        q <= par_word;
      end else if (ser_we && ser_sel == ME) begin
        for (int b = 0; b < OFS_W; b++) begin
          if (ser_pos == CNT_W'(b)) q[b] <= ser_din;
        end
      end
    end
  end

  assign ae = g_slot[0].q;
  assign af = g_slot[1].q;
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] ae,
  input  logic [OFS_W-1:0] af,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid
);
  slot_e rptr_q;
  logic  take;

  assign take = mrst_n && prst_n && ld && rd_en;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rptr_q   <= SLOT_AE;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (!prst_n) begin
      rptr_q   <= SLOT_AE;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= take;
      if (take) begin
        rd_data <= (rptr_q == SLOT_AE) ? ae : af;
        rptr_q  <= next_slot(rptr_q);
      end
    end
  end
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             cfg_serial,
  input  logic             ld,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic             rd_en,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             ser_mode
);
  localparam int CNT_W = $clog2(2 * OFS_W);

  logic             par_we, ser_we;
  slot_e            par_sel, ser_sel;
  logic [CNT_W-1:0] ser_pos;

  ofs_wr_ctrl #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ser_mode(ser_mode),
    .ld(ld), .wr_en(wr_en), .ser_en(ser_en),
    .par_we(par_we), .par_sel(par_sel),
    .ser_we(ser_we), .ser_sel(ser_sel), .ser_pos(ser_pos)
  );

  ofs_store #(.OFS_W(OFS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER), .CNT_W(CNT_W)) u_store (
    .clk(clk), .mrst_n(mrst_n), .cfg_serial(cfg_serial),
    .par_we(par_we), .par_sel(par_sel), .par_word(wr_data),
    .ser_we(ser_we), .ser_sel(ser_sel), .ser_pos(ser_pos), .ser_din(ser_din),
    .ae(ae_ofs), .af(af_ofs), .ser_mode(ser_mode)
  );

  ofs_rd_port #(.OFS_W(OFS_W)) u_rd (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .rd_en(rd_en),
    .ae(ae_ofs), .af(af_ofs), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int OFS_W   = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             ld,
  input logic             wr_en,
  input logic             ser_en,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             ser_mode
);
  localparam logic [OFS_W-1:0] INIT_PAR = OFS_W'(DEF_PAR);
  localparam logic [OFS_W-1:0] INIT_SER = OFS_W'(DEF_SER);

  // R1
  default_after_mrst_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (ae_ofs == (ser_mode ? INIT_SER : INIT_PAR)) &&
                      (af_ofs == (ser_mode ? INIT_SER : INIT_PAR)));

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(ser_mode));

  // R5
  par_ignored_in_ser_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R5
  ser_ignored_in_par_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_mode && !(ld && wr_en)) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R6
  read_gives_valid_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && ld && rd_en) |=> rd_valid);

  // R6
  no_read_no_valid_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !(ld && rd_en) |=> !rd_valid);

  // R8
  prst_keeps_ofs_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs) && !rd_valid));
endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wr_en(wr_en),
  .ser_en(ser_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode)
);

// File: tb/test_ofs_loader.sv
module test_ofs_loader;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         mrst_n = 1'b0, prst_n = 1'b1, cfg_serial = 1'b0;
  logic         ld = 1'b0, wr_en = 1'b0, ser_en = 1'b0, ser_din = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data, ae_ofs, af_ofs;
  logic         rd_valid, ser_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ofs_loader #(.OFS_W(W), .DEF_PAR(127), .DEF_SER(1023)) i_ofs_loader (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_serial(cfg_serial),
    .ld(ld), .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_din(ser_din),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle();
    ld = 0; wr_en = 0; ser_en = 0; ser_din = 0; rd_en = 0; prst_n = 1;
  endtask

  task automatic mreset(input logic sel);
    idle();
    mrst_n = 0; cfg_serial = sel;
    step();
    step();
    mrst_n = 1;
  endtask

  task automatic pwrite(input logic [W-1:0] d);
    ld = 1; wr_en = 1; wr_data = d;
    step();
    ld = 0; wr_en = 0;
  endtask

  task automatic shift_word(input logic [2*W-1:0] bits);
    for (int i = 0; i < 2 * W; i++) begin
      ser_en = 1; ser_din = bits[i];
      step();
    end
    ser_en = 0;
  endtask

  task automatic read_one(input string req, input logic [W-1:0] exp);
    ld = 1; rd_en = 1;
    step();
    ld = 0; rd_en = 0;
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset_defaults();
    mreset(0);
    chk("R1 par ae", ae_ofs, 127);
    chk("R1 par af", af_ofs, 127);
    chk("R1 par mode", ser_mode, 0);
    chk("R6 valid idle", rd_valid, 0);
    mreset(1);
    chk("R1 ser ae", ae_ofs, 1023);
    chk("R1 ser af", af_ofs, 1023);
    chk("R1 ser mode", ser_mode, 1);
  endtask

  task automatic t_parallel_load();
    mreset(0);
    pwrite(16'h0123);
    chk("R3 first ae", ae_ofs, 16'h0123);
    chk("R3 first af kept", af_ofs, 127);
    pwrite(16'hBEEF);
    chk("R3 second af", af_ofs, 16'hBEEF);
    pwrite(16'h0042);
    chk("R3 wrap ae", ae_ofs, 16'h0042);
    chk("R3 wrap af kept", af_ofs, 16'hBEEF);
  endtask

  task automatic t_serial_load();
    mreset(1);
    shift_word({16'h1234, 16'hA5C3});
    chk("R4 ae", ae_ofs, 16'hA5C3);
    chk("R4 af", af_ofs, 16'h1234);
    shift_word({16'h1234, 16'hA5C3});
    ser_en = 1; ser_din = 1;
    repeat (4) step();
    ser_en = 0;
    chk("R4 wrap ae", ae_ofs, 16'hA5CF);
    chk("R4 wrap af", af_ofs, 16'h1234);
  endtask

  task automatic t_cross_mode_ignored();
    mreset(1);
    pwrite(16'h5555);
    chk("R5 par in ser ae", ae_ofs, 1023);
    chk("R5 par in ser af", af_ofs, 1023);
    mreset(0);
    ser_en = 1; ser_din = 0;
    repeat (5) step();
    ser_en = 0;
    chk("R5 ser in par ae", ae_ofs, 127);
    chk("R5 ser in par af", af_ofs, 127);
  endtask

  task automatic t_mode_fixed();
    mreset(0);
    cfg_serial = 1;
    step();
    chk("R2 mode held", ser_mode, 0);
    shift_word(32'h0);
    chk("R2 still parallel", ae_ofs, 127);
    pwrite(16'h0777);
    chk("R2 parallel works", ae_ofs, 16'h0777);
    cfg_serial = 0;
    mreset(1);
    cfg_serial = 0;
    step();
    chk("R2 serial held", ser_mode, 1);
  endtask

  task automatic t_readback();
    mreset(0);
    pwrite(16'h0AAA);
    read_one("R7 read ae after one write", 16'h0AAA);
    pwrite(16'h0BBB);
    chk("R7 write slot kept", af_ofs, 16'h0BBB);
    read_one("R6 read af", 16'h0BBB);
    read_one("R6 read wraps", 16'h0AAA);
    step();
    chk("R6 valid drops", rd_valid, 0);
    mreset(1);
    shift_word({16'h00F0, 16'h000F});
    read_one("R6 serial read ae", 16'h000F);
    read_one("R6 serial read af", 16'h00F0);
  endtask

  task automatic t_no_strobe();
    mreset(0);
    wr_en = 1; wr_data = 16'hFFFF; rd_en = 1;
    step();
    chk("R9 valid", rd_valid, 0);
    step();
    wr_en = 0; rd_en = 0;
    chk("R9 ae", ae_ofs, 127);
    chk("R9 af", af_ofs, 127);
  endtask

  task automatic t_partial_reset();
    mreset(0);
    pwrite(16'h0101);
    ld = 1; rd_en = 1;
    step();
    prst_n = 0; wr_en = 1; wr_data = 16'h0E0E;
    step();
    chk("R8 valid off", rd_valid, 0);
    chk("R8 ae kept", ae_ofs, 16'h0101);
    chk("R8 af kept", af_ofs, 127);
    chk("R8 mode kept", ser_mode, 0);
    prst_n = 1; wr_en = 0; rd_en = 0; ld = 0;
    pwrite(16'h0202);
    chk("R8 write restarts ae", ae_ofs, 16'h0202);
    chk("R8 af untouched", af_ofs, 127);
    read_one("R8 read restarts", 16'h0202);
    mreset(1);
    ser_en = 1; ser_din = 0;
    repeat (3) step();
    ser_en = 0; prst_n = 0;
    step();
    prst_n = 1;
    shift_word({16'h0000, 16'h3C3C});
    chk("R8 chain restarts", ae_ofs, 16'h3C3C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step();
    t_reset_defaults();
    t_parallel_load();
    t_serial_load();
    t_cross_mode_ignored();
    t_mode_fixed();
    t_readback();
    t_no_strobe();
    t_partial_reset();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule